// File: doc/BRIEF.md
# Quad DAC Bus-Decode Register Bank

This block is the peripheral-side glue between an asynchronous external memory bus and a four-channel, 12-bit output converter. It watches the bus pins (active-low chip enable, word address bits 21:2, active-low write strobe and the low data bits). It decodes a board select against a jumper-set compare value, and from that a device select and a latch select. Each channel has an input register and an output register. A write cycle aimed at the device loads the input register of one channel. A single dummy write to the latch address moves all four input registers to the output registers together, so every output changes in the same cycle.

Codes are offset binary: 0 is negative full scale, 2048 is zero and 4095 is positive full scale. Reset therefore sets every register to midscale. The bus pins are sampled in the block's clock domain. A register loads on the rising edge of the sampled write strobe. The outputs load on the rising edge of the sampled latch strobe, which happens when chip enable goes back high. Channels 3 and 4 have swapped address codes to match a wiring error on the board. A parameter can restore the straight mapping.

Top module: `quad_dac_glue`

## Requirements
- R1: `board_sel_o` is 1 exactly when `ce_n_i` is 0 and address bits 21:18 equal `jumper_i`; otherwise it is 0.
- R2: `dev_cs_n_o` is 0 exactly when board select is true and address bit 4 is 1; otherwise it is 1.
- R3: `latch_n_o` is 0 exactly when board select is true and address bit 5 is 1, so it returns to 1 when `ce_n_i` returns high.
- R4: Address bits 3:2 pick the channel as follows: byte offset 0x10 (bits 00) is channel 1, 0x14 (01) is channel 2, 0x1C (11) is channel 3 and 0x18 (10) is channel 4. Channel k occupies bits [12k-1:12k-12] of `dac_code_o`.
- R5: When the write strobe rises with the device selected, the addressed channel's input register takes `bus_data_i` and no other input register changes.
- R6: Writes to input registers leave `dac_code_o` unchanged until a latch happens.
- R7: A rise of the latch strobe copies all four input registers to `dac_code_o` in one clock. The data and address bits 3:2 of the latch write have no effect.
- R8: After reset, all four input and output codes are 2048.
- R9: A write strobe pulse changes no register when board select is false (jumper mismatch or chip enable high) or when address bit 4 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ce_n_i | input | 1 | Bus chip enable, active low |
| we_n_i | input | 1 | Bus write strobe, active low |
| bus_addr_i | input | 20 | Word address bits 21:2 |
| bus_data_i | input | 12 | Low data bits of the bus |
| jumper_i | input | 4 | Board-select compare value |
| board_sel_o | output | 1 | Decoded board select, active high |
| dev_cs_n_o | output | 1 | Converter chip select, active low |
| latch_n_o | output | 1 | Converter latch strobe, active low |
| dac_code_o | output | 48 | Four 12-bit output codes, channel 1 in the low bits |

## Verification
The checks assume a well-behaved bus master. Address, data and chip enable stay stable for at least two clocks before the write strobe falls and after it rises, and each strobe stays low for several clocks, so the sampled edges line up with the intended transfer. The stimulus drives every cycle through one bus task that keeps these margins. Only the address, data and jumper values are randomized, with the board-select field biased towards a match so that writes and latches happen often.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

   localparam int QD_MAX_CH_W = 8;

   // Swap the two highest channel codes to match the board wiring.
   function automatic logic [QD_MAX_CH_W-1:0] qd_pair_swap(
      input logic [QD_MAX_CH_W-1:0] raw,
      input int                     nch
   );
      if (int'(raw) >= nch - 2)
         return raw ^ 8'd1;
      return raw;
   endfunction

endpackage

// File: rtl/qdac_decode.sv
module qdac_decode #(
   parameter int ADDR_LO      = 2,
   parameter int ADDR_HI      = 21,
   parameter int BS_LSB       = 18,
   parameter int BS_W         = 4,
   parameter int DEV_BIT      = 4,
   parameter int LAT_BIT      = 5,
   parameter int CH_LSB       = 2,
   parameter int CH_W         = 2,
   parameter bit SWAP_HI_PAIR = 1'b1
) (
   input  logic                  ce_n_i,
   input  logic [ADDR_HI:ADDR_LO] addr_i,
   input  logic [BS_W-1:0]       jumper_i,
   output logic                  board_sel_o,
   output logic                  dev_sel_o,
   output logic                  lat_sel_o,
   output logic [CH_W-1:0]       ch_o
);
   localparam int NCH = 1 << CH_W;

   logic [CH_W-1:0] raw_ch;
   logic            unused_addr;

   assign board_sel_o = !ce_n_i && (addr_i[BS_LSB +: BS_W] == jumper_i);
   assign dev_sel_o   = board_sel_o && addr_i[DEV_BIT];
   assign lat_sel_o   = board_sel_o && addr_i[LAT_BIT];
   assign raw_ch      = addr_i[CH_LSB +: CH_W];
   assign unused_addr = ^addr_i;

   generate
      if (SWAP_HI_PAIR) begin : g_swapped
         logic [qdac_pkg::QD_MAX_CH_W-1:0] mapped;
         assign mapped = qdac_pkg::qd_pair_swap(
                            qdac_pkg::QD_MAX_CH_W'(raw_ch), NCH);
         assign ch_o   = mapped[CH_W-1:0];
      end else begin : g_straight
         assign ch_o = raw_ch;
      end
   endgenerate

endmodule

// File: rtl/qdac_sampler.sv
module qdac_sampler #(
   parameter int             W         = 8,
   parameter logic [W-1:0]   IDLE_VAL  = '0
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         q_o <= IDLE_VAL;
      else
         q_o <= d_i;
   end
endmodule

// File: rtl/qdac_bank.sv
module qdac_bank #(
   parameter int CODE_W = 12,
   parameter int CH_W   = 2
) (
   input  logic                        clk_i,
   input  logic                        rst_ni,
   input  logic                        wr_pulse_i,
   input  logic [CH_W-1:0]             wr_ch_i,
   input  logic [CODE_W-1:0]           wr_data_i,
   input  logic                        lat_pulse_i,
   output logic [(1<<CH_W)*CODE_W-1:0] in_code_o,
   output logic [(1<<CH_W)*CODE_W-1:0] out_code_o
);
   localparam int                NCH = 1 << CH_W;
   localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         logic [CODE_W-1:0] in_q;
         logic [CODE_W-1:0] out_q;

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               in_q  <= MID;
               out_q <= MID;
            end else begin
               if (wr_pulse_i && (wr_ch_i == CH_W'(c)))
                  in_q <= wr_data_i;
               if (lat_pulse_i)
                  out_q <= in_q;
            end
         end

         assign in_code_o[c*CODE_W +: CODE_W]  = in_q;
         assign out_code_o[c*CODE_W +: CODE_W] = out_q;
      end
   endgenerate
endmodule

// File: rtl/quad_dac_glue.sv
module quad_dac_glue #(
   parameter int CODE_W       = 12,
   parameter int CH_W         = 2,
   parameter int ADDR_LO      = 2,
   parameter int ADDR_HI      = 21,
   parameter int BS_W         = 4,
   parameter int BS_LSB       = 18,
   parameter int DEV_BIT      = 4,
   parameter int LAT_BIT      = 5,
   parameter int CH_LSB       = 2,
   parameter bit SWAP_HI_PAIR = 1'b1
) (
   input  logic                        clk_i,
   input  logic                        rst_ni,
   input  logic                        ce_n_i,
   input  logic                        we_n_i,
   input  logic [ADDR_HI:ADDR_LO]      bus_addr_i,
   input  logic [CODE_W-1:0]           bus_data_i,
   input  logic [BS_W-1:0]             jumper_i,
   output logic                        board_sel_o,
   output logic                        dev_cs_n_o,
   output logic                        latch_n_o,
   output logic [(1<<CH_W)*CODE_W-1:0] dac_code_o
);
   localparam int NCH = 1 << CH_W;
   // sample vector: {we_n, dev_hit, lat_n, ch, data}
   localparam int SW  = 3 + CH_W + CODE_W;
   localparam logic [SW-1:0] IDLE = {1'b1, 1'b0, 1'b1, {(CH_W+CODE_W){1'b0}}};

   generate
      if (CODE_W < 2 || CODE_W > 32) begin : g_bad_code
         $error("CODE_W out of range");
      end
      if (CH_W < 1 || CH_W > qdac_pkg::QD_MAX_CH_W) begin : g_bad_ch
         $error("CH_W out of range");
      end
      if (BS_LSB < ADDR_LO || BS_LSB + BS_W - 1 > ADDR_HI) begin : g_bad_bs
         $error("board-select field outside address bus");
      end
      if (CH_LSB < ADDR_LO || CH_LSB + CH_W - 1 > ADDR_HI) begin : g_bad_chf
         $error("channel field outside address bus");
      end
      if (DEV_BIT == LAT_BIT) begin : g_bad_sel
         $error("device and latch select bits must differ");
      end
      if (DEV_BIT > ADDR_HI || LAT_BIT > ADDR_HI ||
          DEV_BIT < ADDR_LO || LAT_BIT < ADDR_LO) begin : g_bad_bits
         $error("select bit outside address bus");
      end
   endgenerate

   logic              dev_sel;
   logic              lat_sel;
   logic [CH_W-1:0]   ch_dec;
   logic [SW-1:0]     raw_vec;
   logic [SW-1:0]     s_vec;
   logic [SW-1:0]     p_vec;
   logic              wr_pulse;
   logic              lat_pulse;
   logic [NCH*CODE_W-1:0] in_code;

   qdac_decode #(
      .ADDR_LO(ADDR_LO), .ADDR_HI(ADDR_HI), .BS_LSB(BS_LSB), .BS_W(BS_W),
      .DEV_BIT(DEV_BIT), .LAT_BIT(LAT_BIT), .CH_LSB(CH_LSB), .CH_W(CH_W),
      .SWAP_HI_PAIR(SWAP_HI_PAIR)
   ) i_decode (
      .ce_n_i      (ce_n_i),
      .addr_i      (bus_addr_i),
      .jumper_i    (jumper_i),
      .board_sel_o (board_sel_o),
      .dev_sel_o   (dev_sel),
      .lat_sel_o   (lat_sel),
      .ch_o        (ch_dec)
   );

   assign dev_cs_n_o = !dev_sel;
   assign latch_n_o  = !lat_sel;
   assign raw_vec    = {we_n_i, dev_sel, latch_n_o, ch_dec, bus_data_i};

   qdac_sampler #(.W(SW), .IDLE_VAL(IDLE)) i_samp_s (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw_vec), .q_o(s_vec));
   qdac_sampler #(.W(SW), .IDLE_VAL(IDLE)) i_samp_p (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(s_vec), .q_o(p_vec));

   // rising strobe edges between the two sample stages
   assign wr_pulse  = s_vec[SW-1] && !p_vec[SW-1] && p_vec[SW-2];
   assign lat_pulse = s_vec[SW-3] && !p_vec[SW-3];

   qdac_bank #(.CODE_W(CODE_W), .CH_W(CH_W)) i_bank (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_pulse_i  (wr_pulse),
      .wr_ch_i     (p_vec[CODE_W +: CH_W]),
      .wr_data_i   (p_vec[CODE_W-1:0]),
      .lat_pulse_i (lat_pulse),
      .in_code_o   (in_code),
      .out_code_o  (dac_code_o)
   );

endmodule

// File: rtl/quad_dac_glue_chk.sv
module quad_dac_glue_chk #(
   parameter int CODE_W = 12,
   parameter int CH_W   = 2
) (
   input logic                        clk_i,
   input logic                        rst_ni,
   input logic                        ce_n_i,
   input logic                        board_sel_o,
   input logic                        dev_cs_n_o,
   input logic                        latch_n_o,
   input logic                        lat_pulse,
   input logic [(1<<CH_W)*CODE_W-1:0] in_code,
   input logic [(1<<CH_W)*CODE_W-1:0] dac_code_o
);
   localparam int NCH = 1 << CH_W;

   logic [NCH*CODE_W-1:0] prev_in;
   logic [NCH-1:0]        ch_changed;

   always_ff @(posedge clk_i) prev_in <= in_code;

   always_comb begin
      for (int c = 0; c < NCH; c++)
         ch_changed[c] = (in_code[c*CODE_W +: CODE_W] != prev_in[c*CODE_W +: CODE_W]);
   end

   p_bs_needs_ce_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      board_sel_o |-> !ce_n_i);

   p_cs_needs_bs_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !dev_cs_n_o |-> board_sel_o);

   p_latch_needs_bs_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !latch_n_o |-> board_sel_o);

   p_one_channel_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(ch_changed));

   p_out_only_on_latch_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(dac_code_o) |-> $past(lat_pulse));

   p_latch_copies_all_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(lat_pulse) |-> (dac_code_o == $past(in_code)));

endmodule

bind quad_dac_glue quad_dac_glue_chk #(.CODE_W(CODE_W), .CH_W(CH_W)) i_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .ce_n_i      (ce_n_i),
   .board_sel_o (board_sel_o),
   .dev_cs_n_o  (dev_cs_n_o),
   .latch_n_o   (latch_n_o),
   .lat_pulse   (lat_pulse),
   .in_code     (in_code),
   .dac_code_o  (dac_code_o)
);

// File: tb/test_quad_dac_glue.sv
`timescale 1ns/1ps
module test_quad_dac_glue;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ce_n = 1'b1;
   logic        we_n = 1'b1;
   logic [21:0] addr = '0;
   logic [11:0] data = '0;
   logic [3:0]  jmp = 4'hF;
   logic        board_sel, cs_n, latch_n;
   logic [47:0] code;

   int checks = 0;
   int errors = 0;
   logic [11:0] m_in  [4];
   logic [11:0] m_out [4];

   always #2 clk = ~clk;

   quad_dac_glue i_quad_dac_glue (
      .clk_i(clk), .rst_ni(rst_n), .ce_n_i(ce_n), .we_n_i(we_n),
      .bus_addr_i(addr[21:2]), .bus_data_i(data), .jumper_i(jmp),
      .board_sel_o(board_sel), .dev_cs_n_o(cs_n), .latch_n_o(latch_n),
      .dac_code_o(code));

   function automatic int ch_of(input logic [1:0] a32);
      case (a32)
         2'b00: return 0;
         2'b01: return 1;
         2'b11: return 2;
         default: return 3;
      endcase
   endfunction

   function automatic logic [47:0] model_code();
      return {m_out[3], m_out[2], m_out[1], m_out[0]};
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic bus_write(input logic [21:0] a, input logic [11:0] d);
      logic bs;
      @(negedge clk);
      ce_n = 1'b0; addr = a; data = d;
      wait_n(2);
      we_n = 1'b0;
      wait_n(3);
      we_n = 1'b1;
      wait_n(2);
      ce_n = 1'b1;
      wait_n(4);
      bs = (a[21:18] == jmp);
      if (bs && a[4]) m_in[ch_of(a[3:2])] = d;
      if (bs && a[5]) for (int c = 0; c < 4; c++) m_out[c] = m_in[c];
   endtask

   initial begin
      #(200000 * 4);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int c = 0; c < 4; c++) begin m_in[c] = 12'd2048; m_out[c] = 12'd2048; end
      wait_n(5);
      rst_n = 1'b1;
      wait_n(2);
      // R8: reset midscale, strobes idle
      chk("R8 reset codes", 64'(code), 64'(model_code()));
      chk("R1 idle board select", 64'(board_sel), 64'd0);
      chk("R3 idle latch", 64'(latch_n), 64'd1);

      // decode checks at the ports
      ce_n = 1'b0; addr = 22'h3C0010; #1;
      chk("R1 select match", 64'(board_sel), 64'd1);
      chk("R2 cs on channel write", 64'(cs_n), 64'd0);
      chk("R3 latch idle on channel addr", 64'(latch_n), 64'd1);
      addr = 22'h3C0020; #1;
      chk("R3 latch low on latch addr", 64'(latch_n), 64'd0);
      chk("R2 cs high on latch addr", 64'(cs_n), 64'd1);
      jmp = 4'hE; #1;
      chk("R1 jumper mismatch", 64'(board_sel), 64'd0);
      jmp = 4'hF; ce_n = 1'b1; #1;
      chk("R3 latch rises with ce", 64'(latch_n), 64'd1);
      chk("R1 ce high", 64'(board_sel), 64'd0);
      wait_n(3);

      // R4 channel map, R6 double buffering, R7 latch
      bus_write(22'h3C0010, 12'h111);
      bus_write(22'h3C0014, 12'h222);
      bus_write(22'h3C001C, 12'h333);
      bus_write(22'h3C0018, 12'h444);
      chk("R6 no change before latch", 64'(code), 64'(48'h800_800_800_800));
      bus_write(22'h3C002C, 12'hABC);
      chk("R4 channel map after latch", 64'(code), 64'(48'h444_333_222_111));
      chk("R7 latch copies all", 64'(code), 64'(model_code()));

      // R9 ignored writes
      jmp = 4'h7;
      bus_write(22'h3C0010, 12'hDEA);
      jmp = 4'hF;
      bus_write(22'h3C0004, 12'hBEE);
      bus_write(22'h3C0020, 12'h000);
      chk("R9 unselected writes ignored", 64'(code), 64'(48'h444_333_222_111));

      // R5 extremes, one channel only
      bus_write(22'h3C0014, 12'hFFF);
      bus_write(22'h3C0018, 12'h000);
      bus_write(22'h3C0020, 12'h555);
      chk("R5 extreme codes", 64'(code), 64'(48'h000_333_FFF_111));

      // randomized traffic
      void'($urandom(32'd1234));
      for (int i = 0; i < 300; i++) begin
         logic [21:0] a;
         logic [11:0] d;
         a = 22'($urandom);
         if ($urandom_range(0, 3) != 0) a[21:18] = jmp;
         a[1:0] = 2'b00;
         d = 12'($urandom);
         bus_write(a, d);
         chk(a[5] ? "R7 random latch" : "R6 random write", 64'(code), 64'(model_code()));
      end
      bus_write(22'h3C0020, 12'h0);
      chk("R5 random final input registers", 64'(code), 64'(model_code()));

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule